// File: doc/BRIEF.md
# Configuration Frame Readback Verifier and Corrector

This block keeps the configuration memory of a target programmable device correct by checking it one frame at a time. For each frame it sends a read preamble from flash to the device's configuration port. It then reads the frame back byte by byte and compares every byte with a golden copy held in flash. Last, it sends a read trailer. If any byte differs, the block goes straight on to rewrite the frame: it streams a write preamble, the correct frame payload and a write trailer, all taken from a second flash region. The frames are walked in the order they sit in flash. By default the list has 936 frames, built from five class counts (8, 44, 748, 132 and 4).

A host drives the block with single-cycle commands. It can verify one frame, run complete passes until it aborts, or run a given number of complete passes. It can also clear the error or the status information. The block reports the frame in progress, the last frame that failed, a saturating count of failing frames and a saturating count of completed passes. It also holds the bytes of the most recently read frame in a buffer that the host can read.

Top module: `frame_scrubber`

## Requirements
- R1: After reset the block is idle (`busy` low). `curFrame`, `lastErrFrame`, `errCount` and `cycleCount` are zero, and `runDone`, `runAborted` and `errSeen` are low.
- R2: Flash holds one record of REC = HDR_BYTES + FRAME_BYTES + FTR_BYTES bytes per frame, in the order preamble, payload, trailer. The read record of frame f starts at f*REC and the write record at (NUM_FRAMES + f)*REC. Verifying a frame writes the read preamble to the configuration port, issues exactly FRAME_BYTES `cfgRd` strobes and compares each one with the golden payload, then writes the read trailer. A strobe's data is due in the cycle that follows it.
- R3: Command code 1 verifies the frame at `curFrame`, then advances `curFrame` by one (wrapping from NUM_FRAMES-1 to 0), drops `busy` and sets `runDone`.
- R4: A frame whose read-back differs from its golden payload is rewritten right after its read trailer, from its write record (preamble, payload, trailer). A matching frame causes no such write.
- R5: Each failing frame adds exactly one to `errCount`, however many bytes differ. It also loads `lastErrFrame` with the frame index and sets `errSeen`.
- R6: Command code 3 with a nonzero `cmdCount` restarts at frame 0 and runs exactly `cmdCount` complete passes. It then sets `runDone` and leaves `curFrame` at 0. A count of zero is ignored.
- R7: Command code 2 restarts at frame 0 and runs complete passes without end. Command code 4 stops such a run only after the frame in progress (including its rewrite) has finished. The stop sets `runAborted` and leaves `runDone` unchanged. Code 4 while idle has no effect.
- R8: `cycleCount` rises by one each time frame NUM_FRAMES-1 finishes, in any mode.
- R9: After a frame has been read, `bufData` at `bufAddr` = k gives byte k of the data as read from the device, before any correction.
- R10: Command code 5 clears `errCount`, `lastErrFrame` and `errSeen`. Command code 6 clears `cycleCount`, `runDone` and `runAborted`. Neither command touches the other group.
- R11: `errCount` and `cycleCount` stop at their all-ones value and never wrap.
- R12: Start commands (codes 1, 2 and 3) that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle |
| cmdOp | input | 3 | Command code |
| cmdCount | input | REP_W | Number of passes for code 3 |
| flashRd | output | 1 | Flash read strobe |
| flashAddr | output | FLASH_AW | Flash byte address |
| flashData | input | 8 | Flash byte, valid the cycle after `flashRd` |
| cfgRd | output | 1 | Configuration port read strobe |
| cfgRdata | input | 8 | Read-back byte, valid the cycle after `cfgRd` |
| cfgWr | output | 1 | Configuration port write strobe |
| cfgWdata | output | 8 | Byte written to the configuration port |
| bufAddr | input | IDX_W | Frame buffer read address |
| bufData | output | 8 | Frame buffer read data |
| busy | output | 1 | A command is executing |
| runDone | output | 1 | Last run ended normally (sticky) |
| runAborted | output | 1 | Last run was stopped by abort (sticky) |
| errSeen | output | 1 | A mismatch has been found (sticky) |
| curFrame | output | FRAME_W | Frame being verified, or the next frame to verify |
| lastErrFrame | output | FRAME_W | Index of the last failing frame |
| errCount | output | CNT_W | Saturating count of failing frames |
| cycleCount | output | CNT_W | Saturating count of completed passes |

## Verification
A start command presented in one cycle raises `busy` at the next rising edge. Each byte then takes two cycles: a strobe cycle and a data cycle. A frame costs 2*REC + 1 cycles, or 4*REC + 1 when it is rewritten. The counters, the index registers and the sticky flags all update at the same edge where `busy` falls. Clear commands act at the edge after they are presented. The bench therefore drives inputs and samples outputs at falling edges. After each run it polls `busy` and reads results only at the first falling edge where `busy` is low. It reads the frame buffer only after that point, so every value it checks has already settled.

// File: rtl/fv_pkg.sv
package fv_pkg;

  typedef enum logic [2:0] {
    SEG_RHDR = 3'd0,
    SEG_RDAT = 3'd1,
    SEG_RFTR = 3'd2,
    SEG_WHDR = 3'd3,
    SEG_WDAT = 3'd4,
    SEG_WFTR = 3'd5
  } seg_e;

  typedef enum logic [2:0] {
    OP_NOP         = 3'd0,
    OP_SINGLE      = 3'd1,
    OP_RUN_FOREVER = 3'd2,
    OP_RUN_COUNT   = 3'd3,
    OP_ABORT       = 3'd4,
    OP_CLR_ERR     = 3'd5,
    OP_CLR_STAT    = 3'd6
  } op_e;

  // Strobes from control to datapath
  typedef struct packed {
    seg_e seg;       // flash record segment in progress
    logic doIssue;   // byte strobe cycle
    logic doUse;     // byte data cycle
    logic start;     // begin single frame at current index
    logic restart;   // begin pass sequence at frame 0
    logic frameEnd;  // close out the current frame
    logic errClr;
    logic statClr;
  } strobe_t;

endpackage

// File: rtl/fv_datapath.sv
module fv_datapath
  import fv_pkg::*;
#(
  parameter int NUM_FRAMES  = 936,
  parameter int FRAME_BYTES = 16,
  parameter int HDR_BYTES   = 2,
  parameter int FTR_BYTES   = 2,
  parameter int CNT_W       = 16,
  localparam int REC      = HDR_BYTES + FRAME_BYTES + FTR_BYTES,
  localparam int FRAME_W  = $clog2(NUM_FRAMES),
  localparam int IDX_W    = $clog2(FRAME_BYTES),
  localparam int FLASH_AW = $clog2(2 * NUM_FRAMES * REC)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             st,
  output logic                flashRd,
  output logic [FLASH_AW-1:0] flashAddr,
  input  logic [7:0]          flashData,
  output logic                cfgRd,
  input  logic [7:0]          cfgRdata,
  output logic                cfgWr,
  output logic [7:0]          cfgWdata,
  input  logic [IDX_W-1:0]    bufAddr,
  output logic [7:0]          bufData,
  output logic                lastByte,
  output logic                mismatch,
  output logic                lastFrame,
  output logic [FRAME_W-1:0]  curFrame,
  output logic [FRAME_W-1:0]  lastErrFrame,
  output logic [CNT_W-1:0]    errCount,
  output logic [CNT_W-1:0]    cycleCount,
  output logic                errSeen
);

  localparam logic [FLASH_AW-1:0] WR_BASE   = FLASH_AW'(NUM_FRAMES * REC);
  localparam logic [FLASH_AW-1:0] REC_A     = FLASH_AW'(REC);
  localparam logic [FLASH_AW-1:0] DAT_OFF   = FLASH_AW'(HDR_BYTES);
  localparam logic [FLASH_AW-1:0] FTR_OFF   = FLASH_AW'(HDR_BYTES + FRAME_BYTES);
  localparam logic [FRAME_W-1:0]  FRAME_MAX = FRAME_W'(NUM_FRAMES - 1);

  logic [IDX_W-1:0]    byteIdx;
  logic [IDX_W-1:0]    segLast;
  logic [FLASH_AW-1:0] segOff;
  logic [FLASH_AW-1:0] regionBase;
  logic                isWrite;
  logic                isReadData;
  logic [7:0]          frameBuf [FRAME_BYTES];

  assign isWrite     = (st.seg == SEG_WHDR) || (st.seg == SEG_WDAT) || (st.seg == SEG_WFTR);
  assign isReadData  = (st.seg == SEG_RDAT);
  assign lastFrame   = (curFrame == FRAME_MAX);

  always_comb begin
    case (st.seg)
      SEG_RHDR, SEG_WHDR: begin segLast = IDX_W'(HDR_BYTES - 1);   segOff = '0;      end
      SEG_RDAT, SEG_WDAT: begin segLast = IDX_W'(FRAME_BYTES - 1); segOff = DAT_OFF; end
      default:            begin segLast = IDX_W'(FTR_BYTES - 1);   segOff = FTR_OFF; end
    endcase
  end

  assign lastByte   = (byteIdx == segLast);
  assign regionBase = isWrite ? WR_BASE : '0;
  assign flashAddr  = regionBase + FLASH_AW'(curFrame) * REC_A + segOff + FLASH_AW'(byteIdx);
  assign flashRd    = st.doIssue;
  assign cfgRd      = st.doIssue && isReadData;
  assign cfgWr      = st.doUse && !isReadData;
  assign cfgWdata   = flashData;

  // byte walk and mismatch capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteIdx  <= '0;
      mismatch <= 1'b0;
    end else if (st.start || st.restart || st.frameEnd) begin
      byteIdx  <= '0;
      mismatch <= 1'b0;
    end else if (st.doUse) begin
      byteIdx <= lastByte ? '0 : byteIdx + 1'b1;
      if (isReadData && (cfgRdata != flashData)) mismatch <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st.doUse && isReadData) frameBuf[byteIdx] <= cfgRdata;
  end

  assign bufData = (32'(bufAddr) < FRAME_BYTES) ? frameBuf[bufAddr] : 8'h00;

  // frame index
  always_ff @(posedge clk) begin
    if (!rstN)            curFrame <= '0;
    else if (st.restart)  curFrame <= '0;
    else if (st.frameEnd) curFrame <= lastFrame ? '0 : curFrame + 1'b1;
  end

  // error group
  always_ff @(posedge clk) begin
    if (!rstN || st.errClr) begin
      errCount     <= '0;
      lastErrFrame <= '0;
      errSeen      <= 1'b0;
    end else if (st.frameEnd && mismatch) begin
      if (errCount != '1) errCount <= errCount + 1'b1;
      lastErrFrame <= curFrame;
      errSeen      <= 1'b1;
    end
  end

  // pass counter
  always_ff @(posedge clk) begin
    if (!rstN || st.statClr) cycleCount <= '0;
    else if (st.frameEnd && lastFrame && (cycleCount != '1)) cycleCount <= cycleCount + 1'b1;
  end

  a_r8_frame_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (curFrame <= FRAME_MAX) && (lastErrFrame <= FRAME_MAX));

  a_r2_port_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgRd && cfgWr));

  a_r11_err_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    !st.errClr |=> errCount >= $past(errCount));

  a_r11_cyc_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    !st.statClr |=> cycleCount >= $past(cycleCount));

  a_r5_one_per_frame: assert property (@(posedge clk) disable iff (!rstN)
    !st.errClr |=> (errCount - $past(errCount)) <= CNT_W'(1));

endmodule

// File: rtl/fv_control.sv
module fv_control
  import fv_pkg::*;
#(
  parameter int REP_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [REP_W-1:0] cmdCount,
  input  logic             lastByte,
  input  logic             mismatch,
  input  logic             lastFrame,
  output strobe_t          st,
  output logic             busy,
  output logic             runDone,
  output logic             runAborted
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_USE, S_FEND} state_e;
  typedef enum logic [1:0] {M_SINGLE, M_FOREVER, M_COUNT} mode_e;

  state_e           state, stateNext;
  mode_e            mode, modeNext;
  seg_e             seg, segNext;
  logic [REP_W-1:0] remain, remainNext;
  logic             abortPend;
  logic             abortCmd;
  logic             doneSet, abortSet;

  assign busy     = (state != S_IDLE);
  assign abortCmd = cmdValid && (cmdOp == OP_ABORT);

  always_comb begin
    st         = '0;
    st.seg     = seg;
    st.errClr  = cmdValid && (cmdOp == OP_CLR_ERR);
    st.statClr = cmdValid && (cmdOp == OP_CLR_STAT);
    stateNext  = state;
    modeNext   = mode;
    segNext    = seg;
    remainNext = remain;
    doneSet    = 1'b0;
    abortSet   = 1'b0;
    case (state)
      S_IDLE: begin
        if (cmdValid) begin
          case (cmdOp)
            OP_SINGLE: begin
              modeNext = M_SINGLE; segNext = SEG_RHDR; stateNext = S_ISSUE; st.start = 1'b1;
            end
            OP_RUN_FOREVER: begin
              modeNext = M_FOREVER; segNext = SEG_RHDR; stateNext = S_ISSUE; st.restart = 1'b1;
            end
            OP_RUN_COUNT: begin
              if (cmdCount != '0) begin
                modeNext = M_COUNT; segNext = SEG_RHDR; stateNext = S_ISSUE;
                remainNext = cmdCount; st.restart = 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
      S_ISSUE: begin
        st.doIssue = 1'b1;
        stateNext  = S_USE;
      end
      S_USE: begin
        st.doUse  = 1'b1;
        stateNext = S_ISSUE;
        if (lastByte) begin
          case (seg)
            SEG_RHDR: segNext = SEG_RDAT;
            SEG_RDAT: segNext = SEG_RFTR;
            SEG_RFTR: if (mismatch) segNext = SEG_WHDR; else stateNext = S_FEND;
            SEG_WHDR: segNext = SEG_WDAT;
            SEG_WDAT: segNext = SEG_WFTR;
            default:  stateNext = S_FEND;
          endcase
        end
      end
      default: begin
        st.frameEnd = 1'b1;
        segNext     = SEG_RHDR;
        stateNext   = S_ISSUE;
        if (mode == M_SINGLE) begin
          stateNext = S_IDLE; doneSet = 1'b1;
        end else if (abortPend || abortCmd) begin
          stateNext = S_IDLE; abortSet = 1'b1;
        end else if ((mode == M_COUNT) && lastFrame) begin
          if (remain == REP_W'(1)) begin
            stateNext = S_IDLE; doneSet = 1'b1;
          end else begin
            remainNext = remain - 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      mode   <= M_SINGLE;
      seg    <= SEG_RHDR;
      remain <= '0;
    end else begin
      state  <= stateNext;
      mode   <= modeNext;
      seg    <= segNext;
      remain <= remainNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || (state == S_IDLE) || (stateNext == S_IDLE)) abortPend <= 1'b0;
    else if (abortCmd) abortPend <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runDone    <= 1'b0;
      runAborted <= 1'b0;
    end else begin
      if (doneSet)         runDone <= 1'b1;
      else if (st.statClr) runDone <= 1'b0;
      if (abortSet)        runAborted <= 1'b1;
      else if (st.statClr) runAborted <= 1'b0;
    end
  end

  a_r3_single_stops: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FEND && mode == M_SINGLE) |=> (!busy && runDone));

  a_r7_abort_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FEND && mode != M_SINGLE && abortPend) |=> (!busy && runAborted));

  a_r4_rewrite_needs_mismatch: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ISSUE && seg == SEG_WHDR) |-> mismatch);

  a_r12_busy_keeps_mode: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid && cmdOp != OP_NOP) |=> (mode == $past(mode)));

endmodule

// File: rtl/frame_scrubber.sv
module frame_scrubber
  import fv_pkg::*;
#(
  parameter int N_IOB       = 8,
  parameter int N_IOI       = 44,
  parameter int N_CLB       = 748,
  parameter int N_BRI       = 132,
  parameter int N_GCK       = 4,
  parameter int FRAME_BYTES = 16,
  parameter int HDR_BYTES   = 2,
  parameter int FTR_BYTES   = 2,
  parameter int CNT_W       = 16,
  parameter int REP_W       = 16,
  localparam int NUM_FRAMES = N_IOB + N_IOI + N_CLB + N_BRI + N_GCK,
  localparam int REC        = HDR_BYTES + FRAME_BYTES + FTR_BYTES,
  localparam int FRAME_W    = $clog2(NUM_FRAMES),
  localparam int IDX_W      = $clog2(FRAME_BYTES),
  localparam int FLASH_AW   = $clog2(2 * NUM_FRAMES * REC)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [2:0]          cmdOp,
  input  logic [REP_W-1:0]    cmdCount,
  output logic                flashRd,
  output logic [FLASH_AW-1:0] flashAddr,
  input  logic [7:0]          flashData,
  output logic                cfgRd,
  input  logic [7:0]          cfgRdata,
  output logic                cfgWr,
  output logic [7:0]          cfgWdata,
  input  logic [IDX_W-1:0]    bufAddr,
  output logic [7:0]          bufData,
  output logic                busy,
  output logic                runDone,
  output logic                runAborted,
  output logic                errSeen,
  output logic [FRAME_W-1:0]  curFrame,
  output logic [FRAME_W-1:0]  lastErrFrame,
  output logic [CNT_W-1:0]    errCount,
  output logic [CNT_W-1:0]    cycleCount
);

  strobe_t st;
  logic    lastByte, mismatch, lastFrame;

  fv_control #(.REP_W(REP_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdCount(cmdCount),
    .lastByte(lastByte), .mismatch(mismatch), .lastFrame(lastFrame),
    .st(st), .busy(busy), .runDone(runDone), .runAborted(runAborted)
  );

  fv_datapath #(
    .NUM_FRAMES(NUM_FRAMES), .FRAME_BYTES(FRAME_BYTES), .HDR_BYTES(HDR_BYTES),
    .FTR_BYTES(FTR_BYTES), .CNT_W(CNT_W)
  ) uData (
    .clk(clk), .rstN(rstN), .st(st),
    .flashRd(flashRd), .flashAddr(flashAddr), .flashData(flashData),
    .cfgRd(cfgRd), .cfgRdata(cfgRdata), .cfgWr(cfgWr), .cfgWdata(cfgWdata),
    .bufAddr(bufAddr), .bufData(bufData),
    .lastByte(lastByte), .mismatch(mismatch), .lastFrame(lastFrame),
    .curFrame(curFrame), .lastErrFrame(lastErrFrame),
    .errCount(errCount), .cycleCount(cycleCount), .errSeen(errSeen)
  );

endmodule

// File: tb/tb_frame_scrubber.sv
module tb_frame_scrubber;

  localparam int CLK_PERIOD = 10;
  localparam int NF   = 7;
  localparam int FB   = 16;
  localparam int HDR  = 2;
  localparam int FTR  = 2;
  localparam int REC  = HDR + FB + FTR;
  localparam int CW   = 3;
  localparam int RW   = 8;
  localparam int FW   = $clog2(NF);
  localparam int IW   = $clog2(FB);
  localparam int AW   = $clog2(2 * NF * REC);
  localparam int WD   = 150000;

  // {passes, frame mask, bytes corrupted, err delta, pass delta, last failing frame}
  localparam int VEC [4][6] = '{
    '{1, 7'b0000000, 0,  0, 1, 0},
    '{1, 7'b0000100, 1,  1, 1, 2},
    '{2, 7'b1000001, 3,  2, 2, 6},
    '{1, 7'b0101010, 16, 3, 1, 5}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [2:0]    cmdOp = 3'd0;
  logic [RW-1:0] cmdCount = '0;
  logic          flashRd, cfgRd, cfgWr;
  logic [AW-1:0] flashAddr;
  logic [7:0]    flashData = 8'h00, cfgRdata = 8'h00, cfgWdata, bufData;
  logic [IW-1:0] bufAddr = '0;
  logic          busy, runDone, runAborted, errSeen;
  logic [FW-1:0] curFrame, lastErrFrame;
  logic [CW-1:0] errCount, cycleCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_scrubber #(
    .N_IOB(1), .N_IOI(2), .N_CLB(2), .N_BRI(1), .N_GCK(1),
    .FRAME_BYTES(FB), .HDR_BYTES(HDR), .FTR_BYTES(FTR), .CNT_W(CW), .REP_W(RW)
  ) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdCount(cmdCount),
    .flashRd(flashRd), .flashAddr(flashAddr), .flashData(flashData),
    .cfgRd(cfgRd), .cfgRdata(cfgRdata), .cfgWr(cfgWr), .cfgWdata(cfgWdata),
    .bufAddr(bufAddr), .bufData(bufData), .busy(busy), .runDone(runDone),
    .runAborted(runAborted), .errSeen(errSeen), .curFrame(curFrame),
    .lastErrFrame(lastErrFrame), .errCount(errCount), .cycleCount(cycleCount)
  );

  function automatic logic [7:0] gold(int f, int k);
    return 8'((f * 37 + k * 11 + 5) & 255);
  endfunction

  function automatic logic [7:0] flashFn(int a);
    int region = a / (NF * REC);
    int r = a % (NF * REC);
    int f = r / REC;
    int o = r % REC;
    if (o == 0) return (region != 0) ? 8'hC3 : 8'h3C;
    if (o < HDR) return 8'(f);
    if (o < HDR + FB) return gold(f, o - HDR);
    return 8'h0F;
  endfunction

  // flash and target device model
  logic [7:0] devMem [NF*FB];
  int rdIdx, wrLeft, wrIdx, corrCount, rdCount, rdOverrun;
  logic skipNext;
  logic injGo = 1'b0;
  int injFrame = 0, injN = 0;
  logic [7:0] injXor = 8'h00;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NF*FB; i++) devMem[i] <= gold(i / FB, i % FB);
      rdIdx <= 0; wrLeft <= 0; wrIdx <= 0; skipNext <= 1'b0;
      corrCount <= 0; rdCount <= 0; rdOverrun <= 0;
    end else begin
      if (flashRd) flashData <= flashFn(int'(flashAddr));
      if (cfgRd) begin
        if (rdIdx >= FB) rdOverrun <= rdOverrun + 1;
        else cfgRdata <= devMem[int'(curFrame)*FB + rdIdx];
        rdIdx   <= rdIdx + 1;
        rdCount <= rdCount + 1;
      end
      if (cfgWr) begin
        rdIdx <= 0;
        if (skipNext) skipNext <= 1'b0;
        else if (wrLeft > 0) begin
          devMem[int'(curFrame)*FB + wrIdx] <= cfgWdata;
          wrIdx  <= wrIdx + 1;
          wrLeft <= wrLeft - 1;
        end else if (cfgWdata == 8'hC3) begin
          skipNext <= 1'b1; wrLeft <= FB; wrIdx <= 0; corrCount <= corrCount + 1;
        end
      end
      if (injGo)
        for (int k = 0; k < injN; k++)
          devMem[injFrame*FB + k] <= devMem[injFrame*FB + k] ^ injXor;
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmd(input int op, input int cnt);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'(op); cmdCount = RW'(cnt);
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic inject(input int f, input logic [7:0] x, input int n);
    @(negedge clk);
    injFrame = f; injXor = x; injN = n; injGo = 1'b1;
    @(negedge clk);
    injGo = 1'b0;
  endtask

  function automatic int devDiff();
    int d = 0;
    for (int i = 0; i < NF*FB; i++) if (devMem[i] != gold(i / FB, i % FB)) d++;
    return d;
  endfunction

  initial begin
    repeat (WD) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end

  initial begin
    int e0, c0, k0, r0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 counters", int'(errCount) + int'(cycleCount), 0);
    chk("R1 indices", int'(curFrame) + int'(lastErrFrame), 0);
    chk("R1 flags", {runDone, runAborted, errSeen}, 0);

    // vector table: counted passes with injected corruption
    for (int v = 0; v < 4; v++) begin
      for (int f = 0; f < NF; f++)
        if (((VEC[v][1] >> f) & 1) != 0) inject(f, 8'h5A, VEC[v][2]);
      e0 = errCount; c0 = cycleCount; k0 = corrCount; r0 = rdCount;
      cmd(3, VEC[v][0]);
      waitIdle();
      chk("R5 error delta", int'(errCount) - e0, VEC[v][3]);
      chk("R6 pass delta", int'(cycleCount) - c0, VEC[v][4]);
      if (VEC[v][3] > 0) chk("R5 last failing frame", lastErrFrame, VEC[v][5]);
      chk("R4 rewrites", corrCount - k0, VEC[v][3]);
      chk("R4 device repaired", devDiff(), 0);
      chk("R2 readback strobes", rdCount - r0, VEC[v][0] * NF * FB);
      chk("R2 no overrun", rdOverrun, 0);
      chk("R6 done and index", {runDone, 3'(curFrame)}, 8);
    end

    // R10 clear status keeps error group
    cmd(6, 0);
    chk("R10 status cleared", int'(cycleCount) + int'(runDone), 0);
    chk("R10 errors kept", errCount, 6);

    // R3/R9 single step on corrupted frame 0
    inject(0, 8'h81, 4);
    k0 = corrCount;
    cmd(1, 0);
    waitIdle();
    chk("R3 index advanced", curFrame, 1);
    chk("R3 done", runDone, 1);
    chk("R5 errSeen", errSeen, 1);
    chk("R5 one error", errCount, 7);
    chk("R4 single rewrite", corrCount - k0, 1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); bufAddr = IW'(k); #1;
      chk("R9 buffer byte", bufData, int'((k < 4) ? (gold(0, k) ^ 8'h81) : gold(0, k)));
    end

    // R11 error counter saturation
    inject(1, 8'h10, 1);
    cmd(1, 0);
    waitIdle();
    chk("R11 error saturates", errCount, 7);
    chk("R5 last frame 1", lastErrFrame, 1);

    // R8 wrap via single steps
    for (int s = 0; s < 5; s++) begin cmd(1, 0); waitIdle(); end
    chk("R8 wrapped index", curFrame, 0);
    chk("R8 pass counted", cycleCount, 1);

    // R10 clear error keeps status
    cmd(5, 0);
    chk("R10 error cleared", int'(errCount) + int'(lastErrFrame) + int'(errSeen), 0);
    chk("R10 passes kept", cycleCount, 1);

    // R12 starts while busy ignored
    cmd(3, 1);
    cmd(1, 0);
    cmd(3, 3);
    waitIdle();
    repeat (3) @(negedge clk);
    chk("R12 one pass only", cycleCount, 2);
    chk("R12 idle after", busy, 0);

    // R6 zero count ignored
    cmd(3, 0);
    chk("R6 zero count idle", busy, 0);
    chk("R6 zero count no pass", cycleCount, 2);

    // R7 forever then abort
    cmd(6, 0);
    inject(3, 8'hFF, 2);
    r0 = rdCount;
    cmd(2, 0);
    repeat (2 * NF * (2 * REC + 1) + 40) @(negedge clk);
    chk("R7 still running", busy, 1);
    cmd(4, 0);
    waitIdle();
    chk("R7 aborted flag", runAborted, 1);
    chk("R7 no done", runDone, 0);
    chk("R7 passes run", (cycleCount >= 2) ? 1 : 0, 1);
    chk("R7 whole frames", (rdCount - r0) % FB, 0);
    chk("R7 device repaired", devDiff(), 0);

    // R7 abort while idle
    cmd(6, 0);
    cmd(4, 0);
    chk("R7 idle abort ignored", {busy, runAborted}, 0);

    // R11 pass counter saturation
    cmd(3, 9);
    waitIdle();
    chk("R11 pass saturates", cycleCount, 7);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

endmodule